// File: doc/BRIEF.md
# TDM Time-Slot Assigner

This block sits on one time-division multiplexed serial line and divides every frame among four serial channel controllers: two bearer channels, a monitor/command channel and a signalling (D) channel. It keeps two small routing tables, one for the receive direction and one for the transmit direction. Each table is walked in its own order, one bit time at a time. The walk restarts at entry 0 whenever a frame sync is seen.

Every routing entry gives a slot length in bits or bytes and names the channel that owns the slot. An entry can instead mark the slot as skipped, or as the single D-channel grant bit. An end flag in an entry stops the walk until the next sync, so a frame needs no fixed length. The receive side gives each channel a one-cycle strobe together with the line bit. The transmit side tells a channel when its bit has been taken and drives the line from that bit. For debug, both sides report the index of the entry that handled the latest bit.

Top module: `tsa_core`

## Requirements
- R1: An entry is a 9-bit word: bits [8:6] channel code, bits [5:2] count, bit 1 byte-unit flag, bit 0 end flag. It is written through `cfg_we`/`cfg_addr`/`cfg_data`, and `cfg_tx` selects the transmit table (1) or the receive table (0).
- R2: A slot lasts count+1 bits when the byte-unit flag is 0 and (count+1)*8 bits when it is 1. A grant entry (code 111) with the byte-unit flag at 0 lasts exactly one bit, whatever its count.
- R3: Codes 010, 110, 101 and 011 route the slot to channels 0, 1, 2 and 3. For each receive bit of such a slot, `rx_stb` bit ch is high for exactly the one clock after the `bit_en` edge, and `rx_bit` holds the line bit.
- R4: Codes 000, 001 and 100 skip the slot. No channel is strobed or takes a bit, and `tx_line` is driven 1.
- R5: In a receive grant slot (code 111), `rx_gnt_vld` pulses with `rx_gnt` equal to the line bit, and no channel is strobed. In a transmit grant slot, `tx_line` is 1.
- R6: After the final bit of an entry whose end flag is set, or of the last table entry, the walk stays idle until the next sync. While idle there are no strobes, `tx_line` is 1 and the index output reads 0.
- R7: A bit time with `fsync` high is bit 0 of entry 0, even when it arrives in the middle of a frame.
- R8: The receive and transmit tables are walked independently. Each side follows only its own entries and end flags.
- R9: For each transmit bit of channel ch, `tx_take` bit ch pulses for one clock, and `tx_line` takes the value of `tx_bits[ch]` sampled at that bit time. `tx_line` changes only at `bit_en` edges.
- R10: `rx_idx` and `tx_idx` report the index of the entry that handled the latest bit time.
- R11: After reset all strobes are 0, `tx_line` is 1, both indices are 0, and both walks are idle until the first sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle enable marking one bit time on the line |
| fsync | input | 1 | Frame sync, sampled together with bit_en |
| cfg_we | input | 1 | Routing table write enable |
| cfg_tx | input | 1 | Table select: 1 transmit, 0 receive |
| cfg_addr | input | AW | Entry index to write |
| cfg_data | input | 9 | Entry word |
| rx_line | input | 1 | Serial receive data |
| rx_stb | output | 4 | Per-channel receive bit strobe |
| rx_bit | output | 1 | Latest received bit |
| rx_gnt_vld | output | 1 | Grant bit valid pulse |
| rx_gnt | output | 1 | Latest grant bit value |
| tx_bits | input | 4 | Next transmit bit offered by each channel |
| tx_take | output | 4 | Per-channel transmit bit consumed pulse |
| tx_line | output | 1 | Serial transmit data, 1 when released |
| rx_idx | output | AW | Receive entry index of the latest bit |
| tx_idx | output | AW | Transmit entry index of the latest bit |

## Verification
A corrupted entry index or bit position inside a walker moves the slot boundaries. At the very next `bit_en`, a strobe then lands on the wrong channel or a skipped bit is routed, and the index output differs from the expected value in that same bit time. A walk that misses its end flag keeps strobing into the idle region, and a missed restart on sync shows up at the sync bit. Both become visible within one bit time. The bench compares every output after every bit time against its own model of the tables, using the GCI-style frame, a shortened table and random tables with random mid-frame syncs.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int CODE_W  = 3;
  localparam int CNT_W   = 4;
  localparam int ENTRY_W = CODE_W + CNT_W + 2;
  localparam int NCH     = 4;
  localparam int POS_W   = CNT_W + 3;

  localparam logic [CODE_W-1:0] CS_SKIP = 3'b000;
  localparam logic [CODE_W-1:0] CS_B1   = 3'b010;
  localparam logic [CODE_W-1:0] CS_B2   = 3'b110;
  localparam logic [CODE_W-1:0] CS_MON  = 3'b101;
  localparam logic [CODE_W-1:0] CS_D    = 3'b011;
  localparam logic [CODE_W-1:0] CS_GNT  = 3'b111;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  cnt;
    logic              byte_u;
    logic              last;
  } tsa_entry_t;

  function automatic logic [NCH-1:0] chan_onehot(input logic [CODE_W-1:0] code);
    logic [NCH-1:0] oh;
    oh = '0;
    case (code)
      CS_B1:   oh[0] = 1'b1;
      CS_B2:   oh[1] = 1'b1;
      CS_MON:  oh[2] = 1'b1;
      CS_D:    oh[3] = 1'b1;
      default: oh = '0;
    endcase
    return oh;
  endfunction

  function automatic logic [POS_W-1:0] slot_last_pos(input tsa_entry_t e);
    logic [POS_W-1:0] r;
    if (e.byte_u)              r = {e.cnt, 3'b111};
    else if (e.code == CS_GNT) r = '0;
    else                       r = POS_W'(e.cnt);
    return r;
  endfunction
endpackage

// File: rtl/tsa_route_ram.sv
module tsa_route_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tsa_walker.sv
module tsa_walker
  import tsa_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          fsync,
  input  tsa_entry_t    entry,
  output logic [AW-1:0] rd_idx,
  output logic          active
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic             run_q;
  logic [AW-1:0]    idx_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] cur_pos;
  logic             slot_end;
  logic             table_end;

  assign active    = fsync | run_q;
  assign rd_idx    = fsync ? '0 : idx_q;
  assign cur_pos   = fsync ? '0 : pos_q;
  assign slot_end  = (cur_pos == slot_last_pos(entry));
  assign table_end = entry.last | (rd_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      idx_q <= '0;
      pos_q <= '0;
    end else if (bit_en && active) begin
      if (slot_end) begin
        pos_q <= '0;
        if (table_end) begin
          run_q <= 1'b0;
          idx_q <= '0;
        end else begin
          run_q <= 1'b1;
          idx_q <= rd_idx + 1'b1;
        end
      end else begin
        run_q <= 1'b1;
        idx_q <= rd_idx;
        pos_q <= cur_pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsa_core.sv
module tsa_core
  import tsa_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               fsync,
  input  logic               cfg_we,
  input  logic               cfg_tx,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [ENTRY_W-1:0] cfg_data,
  input  logic               rx_line,
  output logic [NCH-1:0]     rx_stb,
  output logic               rx_bit,
  output logic               rx_gnt_vld,
  output logic               rx_gnt,
  input  logic [NCH-1:0]     tx_bits,
  output logic [NCH-1:0]     tx_take,
  output logic               tx_line,
  output logic [AW-1:0]      rx_idx,
  output logic [AW-1:0]      tx_idx
);
  tsa_entry_t    wk_ent    [2];
  logic [AW-1:0] wk_idx    [2];
  logic          wk_active [2];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [ENTRY_W-1:0] rd_word;

    tsa_route_ram #(.DEPTH(DEPTH), .W(ENTRY_W)) u_ram (
      .clk   (clk),
      .we    (cfg_we && (cfg_tx == 1'(d))),
      .waddr (cfg_addr),
      .wdata (cfg_data),
      .raddr (wk_idx[d]),
      .rdata (rd_word)
    );

    assign wk_ent[d] = tsa_entry_t'(rd_word);

    tsa_walker #(.DEPTH(DEPTH)) u_walk (
      .clk    (clk),
      .rst    (rst),
      .bit_en (bit_en),
      .fsync  (fsync),
      .entry  (wk_ent[d]),
      .rd_idx (wk_idx[d]),
      .active (wk_active[d])
    );
  end

  logic [NCH-1:0] rx_sel;
  logic [NCH-1:0] tx_sel;
  logic           rx_is_gnt;

  assign rx_sel    = wk_active[0] ? chan_onehot(wk_ent[0].code) : '0;
  assign tx_sel    = wk_active[1] ? chan_onehot(wk_ent[1].code) : '0;
  assign rx_is_gnt = wk_active[0] && (wk_ent[0].code == CS_GNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_stb     <= '0;
      rx_bit     <= 1'b0;
      rx_gnt_vld <= 1'b0;
      rx_gnt     <= 1'b0;
      tx_take    <= '0;
      tx_line    <= 1'b1;
      rx_idx     <= '0;
      tx_idx     <= '0;
    end else begin
      rx_stb     <= '0;
      rx_gnt_vld <= 1'b0;
      tx_take    <= '0;
      if (bit_en) begin
        rx_stb  <= rx_sel;
        rx_bit  <= rx_line;
        if (rx_is_gnt) begin
          rx_gnt_vld <= 1'b1;
          rx_gnt     <= rx_line;
        end
        rx_idx  <= wk_active[0] ? wk_idx[0] : '0;
        tx_take <= tx_sel;
        tx_line <= (|tx_sel) ? |(tx_bits & tx_sel) : 1'b1;
        tx_idx  <= wk_active[1] ? wk_idx[1] : '0;
      end
    end
  end
endmodule

// File: rtl/tsa_core_chk.sv
module tsa_core_chk
  import tsa_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst,
  input logic               bit_en,
  input logic               fsync,
  input logic [NCH-1:0]     rx_stb,
  input logic               rx_gnt_vld,
  input logic [NCH-1:0]     tx_take,
  input logic               tx_line,
  input logic [AW-1:0]      rx_idx,
  input logic [AW-1:0]      tx_idx
);
  p_rx_onehot_r3: assert property (@(posedge clk) disable iff (rst) $onehot0(rx_stb));

  p_rx_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_stb != '0) |-> $past(bit_en));

  p_gnt_excl_r5: assert property (@(posedge clk) disable iff (rst)
    rx_gnt_vld |-> (rx_stb == '0));

  p_tx_release_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(bit_en) && (tx_take == '0)) |-> tx_line);

  p_sync_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (bit_en && fsync) |=> ((rx_idx == '0) && (tx_idx == '0)));

  p_tx_onehot_r9: assert property (@(posedge clk) disable iff (rst) $onehot0(tx_take));

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en) |-> $stable(tx_line));
endmodule

bind tsa_core tsa_core_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tsa_core_bench.sv
module tsa_core_bench;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, fsync = 1'b0;
  logic cfg_we = 1'b0, cfg_tx = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [8:0] cfg_data = '0;
  logic rx_line = 1'b0;
  logic [3:0] tx_bits = '0;
  logic [3:0] rx_stb, tx_take;
  logic rx_bit, rx_gnt_vld, rx_gnt, tx_line;
  logic [AW-1:0] rx_idx, tx_idx;

  always #2 clk = ~clk;

  tsa_core #(.DEPTH(DEPTH)) u_tsa_core (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [8:0] rxt [DEPTH];
  logic [8:0] txt [DEPTH];
  bit m_run [2];
  int m_idx [2];
  int m_pos [2];
  int obs [5];

  function automatic logic [8:0] mk(int code, int cnt, bit b, bit l);
    return {3'(code), 4'(cnt), b, l};
  endfunction

  function automatic logic [3:0] exp_oh(logic [2:0] code);
    case (code)
      3'b010: return 4'b0001;
      3'b110: return 4'b0010;
      3'b101: return 4'b0100;
      3'b011: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic int slot_len(logic [8:0] e);
    if (e[1]) return (int'(e[5:2]) + 1) * 8;
    if (e[8:6] == 3'b111) return 1;
    return int'(e[5:2]) + 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic mstep(int d, bit fs, output bit act, output logic [8:0] e, output int ci);
    if (fs) begin m_idx[d] = 0; m_pos[d] = 0; end
    act = fs || m_run[d];
    ci  = m_idx[d];
    e   = (d == 0) ? rxt[ci] : txt[ci];
    if (act) begin
      if (m_pos[d] == slot_len(e) - 1) begin
        m_pos[d] = 0;
        if (e[0] || ci == DEPTH - 1) begin m_run[d] = 0; m_idx[d] = 0; end
        else begin m_run[d] = 1; m_idx[d] = ci + 1; end
      end else begin
        m_run[d] = 1;
        m_pos[d]++;
      end
    end
  endtask

  task automatic write_tables();
    for (int i = 0; i < DEPTH; i++) begin
      for (int d = 0; d < 2; d++) begin
        @(negedge clk);
        cfg_we = 1; cfg_tx = 1'(d); cfg_addr = AW'(i);
        cfg_data = (d == 0) ? rxt[i] : txt[i];
      end
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  // one bit time: drive, check after the bit_en edge, then check pulses cleared
  task automatic one_bit(bit fs, string tag_all);
    bit ra, ta;
    logic [8:0] re, te;
    int ri, ti;
    logic [3:0] eo, to;
    logic rl, etx;
    string tg;
    rl = 1'($urandom);
    @(negedge clk);
    bit_en = 1; fsync = fs; rx_line = rl; tx_bits = 4'($urandom);
    mstep(0, fs, ra, re, ri);
    mstep(1, fs, ta, te, ti);
    eo  = ra ? exp_oh(re[8:6]) : 4'b0;
    to  = ta ? exp_oh(te[8:6]) : 4'b0;
    etx = (to != 0) ? |(tx_bits & to) : 1'b1;
    @(negedge clk);
    bit_en = 0; fsync = 0;
    if (tag_all != "") tg = tag_all;
    else if (!ra) tg = "R6";
    else if (re[8:6] == 3'b111) tg = "R5";
    else if (eo == 0) tg = "R4";
    else tg = "R3";
    chk(tg, 32'(rx_stb), 32'(eo));
    chk("R3", 32'(rx_bit), 32'(rl));
    chk("R5", 32'(rx_gnt_vld), 32'(ra && re[8:6] == 3'b111));
    if (ra && re[8:6] == 3'b111) chk("R5", 32'(rx_gnt), 32'(rl));
    chk("R9", 32'(tx_take), 32'(to));
    chk(ta ? "R9" : "R6", 32'(tx_line), 32'(etx));
    chk(fs ? "R7" : "R10", 32'(rx_idx), 32'(ra ? ri : 0));
    chk(fs ? "R7" : "R10", 32'(tx_idx), 32'(ta ? ti : 0));
    for (int c = 0; c < 4; c++) if (rx_stb[c]) obs[c]++;
    if (rx_gnt_vld) obs[4]++;
    @(negedge clk);
    chk("R3", 32'({rx_stb, rx_gnt_vld, tx_take}), 32'd0);
    chk("R9", 32'(tx_line), 32'(etx));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int d = 0; d < 2; d++) begin m_run[d] = 0; m_idx[d] = 0; m_pos[d] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11", 32'({rx_stb, rx_gnt_vld, tx_take}), 32'd0);
    chk("R11", 32'(tx_line), 32'd1);
    chk("R11", 32'({rx_idx, tx_idx}), 32'd0);

    // directed: GCI-style frame on receive, shortened table on transmit (R1, R8)
    for (int i = 0; i < DEPTH; i++) begin rxt[i] = 9'd0; txt[i] = 9'd0; end
    rxt[0] = mk(2, 0, 1, 0); rxt[1] = mk(6, 0, 1, 0); rxt[2] = mk(5, 0, 1, 0);
    rxt[3] = mk(3, 1, 0, 0); rxt[4] = mk(5, 5, 0, 0); rxt[5] = mk(0, 6, 1, 0);
    rxt[6] = mk(0, 1, 0, 0); rxt[7] = mk(7, 0, 0, 1);
    for (int i = 0; i < 5; i++) txt[i] = rxt[i];
    txt[4][0] = 1'b1;
    write_tables();
    // R11: no activity before first sync
    for (int b = 0; b < 4; b++) one_bit(0, "R11");
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 5; c++) obs[c] = 0;
      for (int b = 0; b < 95; b++) one_bit(b == 0, b < 32 ? "R1" : (b < 91 ? "R8" : "R6"));
      chk("R2", obs[0], 8);
      chk("R2", obs[1], 8);
      chk("R2", obs[2], 14);
      chk("R2", obs[3], 2);
      chk("R2", obs[4], 1);
    end
    // directed mid-frame sync
    for (int b = 0; b < 12; b++) one_bit(b == 0, "");
    one_bit(1, "R7");
    for (int b = 0; b < 10; b++) one_bit(0, "");

    // random tables with random mid-frame syncs
    for (int r = 0; r < 8; r++) begin
      int lp;
      lp = (r % 4 == 3) ? -1 : int'($urandom % DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
        rxt[i] = mk(int'($urandom % 8), int'($urandom % 16), ($urandom % 4) == 0, i == lp);
        txt[i] = mk(int'($urandom % 8), int'($urandom % 16), ($urandom % 4) == 0, i == lp / 2);
      end
      write_tables();
      for (int b = 0; b < 400; b++) one_bit(b == 0 || ($urandom % 70) == 0, "");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule